// File: doc/BRIEF.md
# Shadow Stack Pointer Execution Unit

This block owns the shadow stack pointer used for return-address protection and carries out the operations that work on it. The operations are push, pop, read-pointer, link-register check and an atomic swap. The stack grows toward lower addresses, and the pointer always holds the address of the newest entry. Memory operations use a single-outstanding request port. That port carries an address, write data, a write enable and a locked (atomic) flag. It receives read data, an acknowledge and an access-fault indication.

The pipeline front end presents one decoded operation at a time. With it come the destination register index, the source operand, the swap address, the two link-register values and a protection-enable bit for the current privilege context. Each operation ends with a one-cycle done pulse. The pulse may come with a register writeback, an exception code, or both. Software can overwrite the pointer through a CSR-style write port, and the current pointer is always visible on a read port.

Top module: `ssp_exec_unit`

## Requirements
- R1: After reset the pointer reads 0, `op_ready` is 1, and `mem_req`, `done` and `wb_valid` are 0.
- R2: Push (code 0) requests a write of the source at pointer − XLEN/8. When the write is acknowledged without fault, the pointer becomes that address and no writeback occurs.
- R3: Pop (code 1) requests a read at the current pointer. When the read is acknowledged without fault, the read word is written back to rd and the pointer becomes the read address + XLEN/8.
- R4: Read-pointer (code 2) writes the current pointer back to rd, with no memory request.
- R5: Check (code 3) raises exception code 3 (illegal instruction) when x1 ≠ x5, and completes with code 0 when they are equal. It never writes back. Codes 5–7 always complete with code 3.
- R6: Swap (code 4) issues one request with `mem_we`=1 and `mem_lock`=1 at the operand address. It writes back the returned old word and leaves the pointer unchanged.
- R7: A pointer (push, pop) or swap address with any of its low log2(XLEN/8) bits set completes without a memory request and leaves the pointer unchanged. Pop then reports code 1; push and swap report code 2.
- R8: A memory acknowledge with `mem_fault`=1 leaves the pointer unchanged and gives no writeback. Pop then reports code 4; push and swap report code 5.
- R9: With `prot_en`=0 every operation, including a mismatching check, writes 0 to rd, reports code 0, makes no request and leaves the pointer unchanged.
- R10: `op_ready` is 0 while a memory request is pending, and an operation offered then is ignored.
- R11: A CSR write sets the pointer on the next edge. If a push or pop completion updates the pointer on the same edge, the completion value wins.
- R12: `done` rises one cycle after acceptance for operations without memory access. For operations with memory access, it rises one cycle after the edge that samples `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, accepts an operation |
| op_code | input | 3 | 0 push, 1 pop, 2 read-pointer, 3 check, 4 swap |
| op_rd | input | IDX_W | Destination register index |
| op_src | input | XLEN | Source operand (push data, swap data) |
| op_addr | input | XLEN | Swap address |
| op_x1 | input | XLEN | First link register value for check |
| op_x5 | input | XLEN | Second link register value for check |
| prot_en | input | 1 | Protection active in current context |
| csr_we | input | 1 | Pointer write strobe |
| csr_wdata | input | XLEN | Pointer write value |
| csr_rdata | output | XLEN | Current pointer |
| mem_req | output | 1 | Memory request pending |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Request write data |
| mem_we | output | 1 | Request is a write (or swap) |
| mem_lock | output | 1 | Request is an atomic swap |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | XLEN | Read data, valid with ack |
| mem_fault | input | 1 | Access fault, valid with ack |
| wb_valid | output | 1 | Register writeback |
| wb_idx | output | IDX_W | Writeback register index |
| wb_data | output | XLEN | Writeback value |
| done | output | 1 | Operation complete pulse |
| exc_code | output | 3 | 0 none, 1 load misaligned, 2 store misaligned, 3 illegal, 4 load fault, 5 store fault |

## Verification
The hardest case to reach from the ports is a CSR write landing on exactly the edge where a push completion also moves the pointer. The only visible cue for that edge is the acknowledge the bench itself returns. So the bench's memory responder raises the CSR strobe in the same cycle it raises `mem_ack`, when a flag asks it to. Offering an operation while a request is held open also needs control of the response. The responder's latency is therefore adjustable, so the wait can be stretched and a second operation presented during it.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [2:0] OPC_PUSH  = 3'd0;
  localparam logic [2:0] OPC_POP   = 3'd1;
  localparam logic [2:0] OPC_RDPTR = 3'd2;
  localparam logic [2:0] OPC_CHECK = 3'd3;
  localparam logic [2:0] OPC_SWAP  = 3'd4;

  typedef enum logic [2:0] {
    EXC_NONE     = 3'd0,
    EXC_LD_MISAL = 3'd1,
    EXC_ST_MISAL = 3'd2,
    EXC_ILLEGAL  = 3'd3,
    EXC_LD_FAULT = 3'd4,
    EXC_ST_FAULT = 3'd5
  } ssp_exc_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_MEM  = 1'b1
  } ssp_seq_e;
endpackage

// File: rtl/ssp_ptr_reg.sv
module ssp_ptr_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            upd_en,
  input  logic [XLEN-1:0] upd_val,
  output logic [XLEN-1:0] ssp_q
);
  logic            ptr_en;
  logic [XLEN-1:0] ptr_d;

  // completion update has priority over a software write on the same edge
  always_comb begin
    ptr_en = csr_we | upd_en;
    ptr_d  = upd_en ? upd_val : csr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssp_q <= '0;
    end else if (ptr_en) begin
      ssp_q <= ptr_d;
    end
  end
endmodule

// File: rtl/ssp_addr_gen.sv
module ssp_addr_gen #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] ssp,
  input  logic [XLEN-1:0] swap_addr,
  output logic [XLEN-1:0] push_addr,
  output logic [XLEN-1:0] pop_next,
  output logic            ssp_misal,
  output logic            swap_misal
);
  localparam int STEP_BYTES = XLEN / 8;
  localparam int AL_W       = $clog2(STEP_BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  always_comb begin
    push_addr = ssp - STEP;
    pop_next  = ssp + STEP;
  end

  generate
    if (AL_W > 0) begin : g_align
      always_comb begin
        ssp_misal  = |ssp[AL_W-1:0];
        swap_misal = |swap_addr[AL_W-1:0];
      end
    end else begin : g_noalign
      always_comb begin
        ssp_misal  = 1'b0;
        swap_misal = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [IDX_W-1:0] op_rd,
  input  logic [XLEN-1:0]  op_src,
  input  logic [XLEN-1:0]  op_addr,
  input  logic [XLEN-1:0]  op_x1,
  input  logic [XLEN-1:0]  op_x5,
  input  logic             prot_en,
  input  logic [XLEN-1:0]  ssp,
  input  logic [XLEN-1:0]  push_addr,
  input  logic [XLEN-1:0]  pop_next,
  input  logic             ssp_misal,
  input  logic             swap_misal,
  input  logic             mem_ack,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_fault,
  output logic             op_ready,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             mem_we,
  output logic             mem_lock,
  output logic             upd_en,
  output logic [XLEN-1:0]  upd_val,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic             done,
  output ssp_exc_e         exc_code
);
  ssp_seq_e         state_q, state_d;
  // pending request fields
  logic             req_ld;
  logic [XLEN-1:0]  addr_q, addr_d;
  logic [XLEN-1:0]  wdata_q, wdata_d;
  logic             we_q, we_d;
  logic             lock_q, lock_d;
  logic             isld_q, isld_d;
  logic             upd_q, upd_d;
  logic [XLEN-1:0]  next_q, next_d;
  logic [IDX_W-1:0] rd_q, rd_d;
  // result fields
  logic             done_q, done_d;
  logic             wbv_q, wbv_d;
  ssp_exc_e         exc_q, exc_d;
  logic             res_ld;
  logic [IDX_W-1:0] wbi_q, wbi_d;
  logic [XLEN-1:0]  wbd_q, wbd_d;

  always_comb begin
    state_d = state_q;
    req_ld  = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = we_q;
    lock_d  = lock_q;
    isld_d  = isld_q;
    upd_d   = upd_q;
    next_d  = next_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    wbv_d   = 1'b0;
    exc_d   = EXC_NONE;
    res_ld  = 1'b0;
    wbi_d   = wbi_q;
    wbd_d   = wbd_q;

    case (state_q)
      SEQ_IDLE: begin
        if (op_valid) begin
          rd_d = op_rd;
          if (!prot_en) begin
            done_d = 1'b1;
            wbv_d  = 1'b1;
            res_ld = 1'b1;
            wbi_d  = op_rd;
            wbd_d  = '0;
          end else begin
            case (op_code)
              OPC_PUSH: begin
                if (ssp_misal) begin
                  done_d = 1'b1;
                  exc_d  = EXC_ST_MISAL;
                end else begin
                  state_d = SEQ_MEM;
                  req_ld  = 1'b1;
                  addr_d  = push_addr;
                  wdata_d = op_src;
                  we_d    = 1'b1;
                  lock_d  = 1'b0;
                  isld_d  = 1'b0;
                  upd_d   = 1'b1;
                  next_d  = push_addr;
                end
              end
              OPC_POP: begin
                if (ssp_misal) begin
                  done_d = 1'b1;
                  exc_d  = EXC_LD_MISAL;
                end else begin
                  state_d = SEQ_MEM;
                  req_ld  = 1'b1;
                  addr_d  = ssp;
                  wdata_d = '0;
                  we_d    = 1'b0;
                  lock_d  = 1'b0;
                  isld_d  = 1'b1;
                  upd_d   = 1'b1;
                  next_d  = pop_next;
                end
              end
              OPC_RDPTR: begin
                done_d = 1'b1;
                wbv_d  = 1'b1;
                res_ld = 1'b1;
                wbi_d  = op_rd;
                wbd_d  = ssp;
              end
              OPC_CHECK: begin
                done_d = 1'b1;
                if (op_x1 != op_x5) begin
                  exc_d = EXC_ILLEGAL;
                end
              end
              OPC_SWAP: begin
                if (swap_misal) begin
                  done_d = 1'b1;
                  exc_d  = EXC_ST_MISAL;
                end else begin
                  state_d = SEQ_MEM;
                  req_ld  = 1'b1;
                  addr_d  = op_addr;
                  wdata_d = op_src;
                  we_d    = 1'b1;
                  lock_d  = 1'b1;
                  isld_d  = 1'b0;
                  upd_d   = 1'b0;
                  next_d  = next_q;
                end
              end
              default: begin
                done_d = 1'b1;
                exc_d  = EXC_ILLEGAL;
              end
            endcase
          end
        end
      end
      SEQ_MEM: begin
        if (mem_ack) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
          if (mem_fault) begin
            exc_d = isld_q ? EXC_LD_FAULT : EXC_ST_FAULT;
          end else if (!we_q || lock_q) begin
            wbv_d  = 1'b1;
            res_ld = 1'b1;
            wbi_d  = rd_q;
            wbd_d  = mem_rdata;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      wbv_q   <= 1'b0;
      exc_q   <= EXC_NONE;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      wbv_q   <= wbv_d;
      exc_q   <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      lock_q  <= 1'b0;
      isld_q  <= 1'b0;
      upd_q   <= 1'b0;
      next_q  <= '0;
    end else if (req_ld) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      lock_q  <= lock_d;
      isld_q  <= isld_d;
      upd_q   <= upd_d;
      next_q  <= next_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (state_q == SEQ_IDLE && op_valid) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbi_q <= '0;
      wbd_q <= '0;
    end else if (res_ld) begin
      wbi_q <= wbi_d;
      wbd_q <= wbd_d;
    end
  end

  always_comb begin
    op_ready  = (state_q == SEQ_IDLE);
    mem_req   = (state_q == SEQ_MEM);
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    mem_we    = we_q;
    mem_lock  = lock_q;
    upd_en    = (state_q == SEQ_MEM) && mem_ack && !mem_fault && upd_q;
    upd_val   = next_q;
    wb_valid  = wbv_q;
    wb_idx    = wbi_q;
    wb_data   = wbd_q;
    done      = done_q;
    exc_code  = exc_q;
  end
endmodule

// File: rtl/ssp_exec_unit.sv
module ssp_exec_unit
  import ssp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_code,
  input  logic [IDX_W-1:0] op_rd,
  input  logic [XLEN-1:0]  op_src,
  input  logic [XLEN-1:0]  op_addr,
  input  logic [XLEN-1:0]  op_x1,
  input  logic [XLEN-1:0]  op_x5,
  input  logic             prot_en,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             mem_we,
  output logic             mem_lock,
  input  logic             mem_ack,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_fault,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic             done,
  output logic [2:0]       exc_code
);
  logic [XLEN-1:0] ssp;
  logic [XLEN-1:0] push_addr;
  logic [XLEN-1:0] pop_next;
  logic            ssp_misal;
  logic            swap_misal;
  logic            upd_en;
  logic [XLEN-1:0] upd_val;
  ssp_exc_e        exc_e;

  ssp_ptr_reg #(.XLEN(XLEN)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .upd_en    (upd_en),
    .upd_val   (upd_val),
    .ssp_q     (ssp)
  );

  ssp_addr_gen #(.XLEN(XLEN)) u_agen (
    .ssp        (ssp),
    .swap_addr  (op_addr),
    .push_addr  (push_addr),
    .pop_next   (pop_next),
    .ssp_misal  (ssp_misal),
    .swap_misal (swap_misal)
  );

  ssp_seq #(.XLEN(XLEN), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_rd      (op_rd),
    .op_src     (op_src),
    .op_addr    (op_addr),
    .op_x1      (op_x1),
    .op_x5      (op_x5),
    .prot_en    (prot_en),
    .ssp        (ssp),
    .push_addr  (push_addr),
    .pop_next   (pop_next),
    .ssp_misal  (ssp_misal),
    .swap_misal (swap_misal),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_fault  (mem_fault),
    .op_ready   (op_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .upd_en     (upd_en),
    .upd_val    (upd_val),
    .wb_valid   (wb_valid),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .done       (done),
    .exc_code   (exc_e)
  );

  assign csr_rdata = ssp;
  assign exc_code  = exc_e;
endmodule

// File: rtl/ssp_exec_unit_chk.sv
module ssp_exec_unit_chk #(
  parameter int XLEN  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic [2:0]      op_code,
  input logic            prot_en,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_we,
  input logic            mem_lock,
  input logic            mem_ack,
  input logic            mem_fault,
  input logic            wb_valid,
  input logic [XLEN-1:0] wb_data,
  input logic            done,
  input logic [2:0]      exc_code
);
  localparam int AL_W = $clog2(XLEN / 8);

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  lock_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_lock |-> mem_we);

  // R7
  misal_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && prot_en && op_code == 3'd0 && !csr_we &&
    (|csr_rdata[AL_W-1:0])
    |=> !mem_req && done && exc_code == 3'd2 && $stable(csr_rdata));

  // R9
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && !prot_en && !csr_we
    |=> done && wb_valid && wb_data == '0 && exc_code == 3'd0 && !mem_req
        && $stable(csr_rdata));

  // R11
  csr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !mem_req |=> csr_rdata == $past(csr_wdata));

  // R2
  push_moves_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_fault && mem_we && !mem_lock
    |=> csr_rdata == $past(mem_addr) && done && !wb_valid);

  // R8
  fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_fault |=> done && !wb_valid && exc_code >= 3'd4);
endmodule

bind ssp_exec_unit ssp_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_code   (op_code),
  .prot_en   (prot_en),
  .csr_we    (csr_we),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .mem_ack   (mem_ack),
  .mem_fault (mem_fault),
  .wb_valid  (wb_valid),
  .wb_data   (wb_data),
  .done      (done),
  .exc_code  (exc_code)
);

// File: tb/ssp_exec_unit_test.sv
module ssp_exec_unit_test;
  localparam int XLEN  = 64;
  localparam int IDX_W = 5;
  localparam logic [XLEN-1:0] FAULT_BASE = 64'hF000;

  logic             clk;
  logic             rst_n;
  logic             op_valid;
  logic             op_ready;
  logic [2:0]       op_code;
  logic [IDX_W-1:0] op_rd;
  logic [XLEN-1:0]  op_src, op_addr, op_x1, op_x5;
  logic             prot_en;
  logic             csr_we;
  logic [XLEN-1:0]  csr_wdata, csr_rdata;
  logic             mem_req, mem_we, mem_lock, mem_ack, mem_fault;
  logic [XLEN-1:0]  mem_addr, mem_wdata, mem_rdata;
  logic             wb_valid, done;
  logic [IDX_W-1:0] wb_idx;
  logic [XLEN-1:0]  wb_data;
  logic [2:0]       exc_code;

  ssp_exec_unit #(.XLEN(XLEN), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_rd(op_rd), .op_src(op_src), .op_addr(op_addr),
    .op_x1(op_x1), .op_x5(op_x5), .prot_en(prot_en), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_fault(mem_fault), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .done(done), .exc_code(exc_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [XLEN-1:0] store [logic [XLEN-1:0]];
  logic [XLEN-1:0] m_ssp;
  bit              m_busy;
  int              m_kind;   // 0 push, 1 pop, 4 swap
  logic [XLEN-1:0] m_addr, m_wdata, m_next;
  logic [IDX_W-1:0] m_rd;
  bit              e_done, e_wbv;
  logic [IDX_W-1:0] e_wbi;
  logic [XLEN-1:0] e_wbd;
  int              e_exc;
  string           m_tag = "R1";
  bit              live = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ssp = '0; m_busy = 0; e_done = 0; e_wbv = 0; e_exc = 0;
      e_wbi = '0; e_wbd = '0;
    end else begin
      logic [XLEN-1:0] old_ssp;
      old_ssp = m_ssp;
      e_done = 0; e_wbv = 0; e_exc = 0;
      if (csr_we) m_ssp = csr_wdata;
      if (m_busy) begin
        if (op_valid) m_tag = "R10";
        if (mem_ack) begin
          m_busy = 0;
          e_done = 1;
          if (mem_fault) begin
            e_exc = (m_kind == 1) ? 4 : 5;
            m_tag = "R8";
          end else begin
            if (m_kind != 0) begin
              e_wbv = 1; e_wbi = m_rd; e_wbd = mem_rdata;
            end
            if (m_kind != 4) m_ssp = m_next;
            if (m_kind != 1) store[m_addr] = m_wdata;
          end
        end
      end else if (op_valid) begin
        m_rd = op_rd;
        if (!prot_en) begin
          m_tag = "R9"; e_done = 1; e_wbv = 1; e_wbi = op_rd; e_wbd = '0;
        end else if (op_code == 3'd0 || op_code == 3'd1) begin
          if (old_ssp % (XLEN/8) != 0) begin
            m_tag = "R7"; e_done = 1; e_exc = (op_code == 3'd1) ? 1 : 2;
          end else begin
            m_tag  = (op_code == 3'd0) ? "R2" : "R3";
            m_busy = 1;
            m_kind = int'(op_code);
            m_addr = (op_code == 3'd0) ? old_ssp - XLEN/8 : old_ssp;
            m_next = (op_code == 3'd0) ? old_ssp - XLEN/8 : old_ssp + XLEN/8;
            m_wdata = (op_code == 3'd0) ? op_src : '0;
          end
        end else if (op_code == 3'd2) begin
          m_tag = "R4"; e_done = 1; e_wbv = 1; e_wbi = op_rd; e_wbd = old_ssp;
        end else if (op_code == 3'd4) begin
          if (op_addr % (XLEN/8) != 0) begin
            m_tag = "R7"; e_done = 1; e_exc = 2;
          end else begin
            m_tag = "R6"; m_busy = 1; m_kind = 4; m_addr = op_addr;
            m_wdata = op_src;
          end
        end else begin
          m_tag = "R5"; e_done = 1;
          if (op_code != 3'd3 || op_x1 != op_x5) e_exc = 3;
        end
      end
    end
  end

  // ---------------- memory responder ----------------
  int ack_lat = 0;
  int wcnt = 0;
  bit clash_arm = 0;
  bit clash_clear = 0;
  logic [XLEN-1:0] clash_val;

  always @(negedge clk) begin
    if (clash_clear) begin csr_we = 0; clash_clear = 0; end
    if (m_busy && !mem_ack) begin
      if (wcnt >= ack_lat) begin
        mem_ack   = 1;
        mem_fault = (m_addr >= FAULT_BASE);
        mem_rdata = store.exists(m_addr) ? store[m_addr] : '0;
        if (clash_arm) begin
          csr_we = 1; csr_wdata = clash_val; clash_arm = 0; clash_clear = 1;
        end
      end else begin
        wcnt++;
      end
    end else begin
      mem_ack = 0; mem_fault = 0; wcnt = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (live) begin
      chk(op_ready == !m_busy, "R10", "op_ready", XLEN'(op_ready), XLEN'(!m_busy));
      chk(mem_req == m_busy, m_tag, "mem_req", XLEN'(mem_req), XLEN'(m_busy));
      if (m_busy) begin
        chk(mem_addr == m_addr, m_tag, "mem_addr", mem_addr, m_addr);
        chk(mem_we == (m_kind != 1), m_tag, "mem_we", XLEN'(mem_we), XLEN'(m_kind != 1));
        chk(mem_lock == (m_kind == 4), "R6", "mem_lock", XLEN'(mem_lock), XLEN'(m_kind == 4));
        if (m_kind != 1) chk(mem_wdata == m_wdata, m_tag, "mem_wdata", mem_wdata, m_wdata);
      end
      chk(done == e_done, {"R12 ", m_tag}, "done", XLEN'(done), XLEN'(e_done));
      chk(int'(exc_code) == e_exc, m_tag, "exc_code", XLEN'(exc_code), XLEN'(e_exc));
      chk(wb_valid == e_wbv, m_tag, "wb_valid", XLEN'(wb_valid), XLEN'(e_wbv));
      if (e_wbv) begin
        chk(wb_idx == e_wbi, m_tag, "wb_idx", XLEN'(wb_idx), XLEN'(e_wbi));
        chk(wb_data == e_wbd, m_tag, "wb_data", wb_data, e_wbd);
      end
      chk(csr_rdata == m_ssp, m_tag, "pointer", csr_rdata, m_ssp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle_wait();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] code, input logic [IDX_W-1:0] rd,
                       input logic [XLEN-1:0] src, input logic [XLEN-1:0] addr,
                       input logic [XLEN-1:0] x1, input logic [XLEN-1:0] x5);
    op_valid = 1; op_code = code; op_rd = rd; op_src = src; op_addr = addr;
    op_x1 = x1; op_x5 = x5;
    @(negedge clk);
    op_valid = 0;
    idle_wait();
  endtask

  task automatic set_ptr(input logic [XLEN-1:0] v);
    csr_we = 1; csr_wdata = v; m_tag = "R11";
    @(negedge clk);
    csr_we = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; op_rd = 0; op_src = 0; op_addr = 0;
    op_x1 = 0; op_x5 = 0; prot_en = 1; csr_we = 0; csr_wdata = 0;
    mem_ack = 0; mem_fault = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(csr_rdata == '0, "R1", "pointer after reset", csr_rdata, '0);
    chk(op_ready == 1'b1, "R1", "op_ready after reset", XLEN'(op_ready), 1);
    chk(!mem_req && !done && !wb_valid, "R1", "idle outputs", XLEN'({mem_req, done, wb_valid}), 0);
    live = 1;

    set_ptr(64'h1000);                                      // R11
    chk(csr_rdata == 64'h1000, "R11", "csr write", csr_rdata, 64'h1000);
    ack_lat = 0; issue(3'd0, 5'd0, 64'hAAAA_0001, 0, 0, 0); // R2
    ack_lat = 2; issue(3'd0, 5'd0, 64'hBBBB_0002, 0, 0, 0); // R2
    chk(csr_rdata == 64'h0FF0, "R2", "pointer after two pushes", csr_rdata, 64'h0FF0);
    issue(3'd2, 5'd7, 0, 0, 0, 0);                          // R4
    issue(3'd1, 5'd5, 0, 0, 0, 0);                          // R3
    ack_lat = 0; issue(3'd1, 5'd1, 0, 0, 0, 0);             // R3
    chk(csr_rdata == 64'h1000, "R3", "pointer after two pops", csr_rdata, 64'h1000);
    issue(3'd3, 5'd0, 0, 0, 64'h44, 64'h44);                // R5 equal
    issue(3'd3, 5'd0, 0, 0, 64'h44, 64'h48);                // R5 mismatch
    issue(3'd6, 5'd0, 0, 0, 0, 0);                          // R5 unknown code
    issue(3'd4, 5'd9, 64'h1234, 64'h800, 0, 0);             // R6 old 0
    ack_lat = 1; issue(3'd4, 5'd9, 64'h5678, 64'h800, 0, 0); // R6 old 1234
    set_ptr(64'h1004);                                      // R7
    issue(3'd0, 5'd0, 64'h1, 0, 0, 0);
    issue(3'd1, 5'd2, 0, 0, 0, 0);
    issue(3'd4, 5'd2, 64'h1, 64'h803, 0, 0);
    chk(csr_rdata == 64'h1004, "R7", "pointer kept", csr_rdata, 64'h1004);
    set_ptr(64'hF010);                                      // R8
    issue(3'd0, 5'd0, 64'h9, 0, 0, 0);
    issue(3'd1, 5'd3, 0, 0, 0, 0);
    issue(3'd4, 5'd3, 64'h9, 64'hF000, 0, 0);
    chk(csr_rdata == 64'hF010, "R8", "pointer kept", csr_rdata, 64'hF010);
    set_ptr(64'h2000);
    prot_en = 0;                                            // R9
    issue(3'd0, 5'd4, 64'h77, 0, 0, 0);
    issue(3'd1, 5'd4, 0, 0, 0, 0);
    issue(3'd3, 5'd4, 0, 0, 64'h1, 64'h2);
    issue(3'd2, 5'd4, 0, 0, 0, 0);
    chk(csr_rdata == 64'h2000, "R9", "pointer kept", csr_rdata, 64'h2000);
    prot_en = 1;
    // R10 busy: a pop offered while a slow push is pending is ignored
    ack_lat = 4;
    op_valid = 1; op_code = 3'd0; op_src = 64'hCAFE; op_rd = 0;
    @(negedge clk);
    op_code = 3'd1; op_rd = 5'd6;
    @(negedge clk);
    op_valid = 0;
    idle_wait();
    chk(csr_rdata == 64'h1FF8, "R10", "only push took effect", csr_rdata, 64'h1FF8);
    // R11 same-edge clash: completion value wins
    ack_lat = 1; clash_val = 64'h3000; clash_arm = 1;
    issue(3'd0, 5'd0, 64'hD00D, 0, 0, 0);
    chk(csr_rdata == 64'h1FF0, "R11", "completion wins", csr_rdata, 64'h1FF0);
    issue(3'd1, 5'd8, 0, 0, 0, 0);                          // R3 readback
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule